// File: doc/BRIEF.md
# Wake-up Interrupt Monitor

This always-on block watches a configurable set of wake-up pins while the main processor is asleep. Each pin has four configuration bits: enable, rising-edge select, falling-edge select and level polarity. It also has a sticky status bit. All of these bits are packed 32 pins to a 32-bit word and reached through a simple word-addressed register port. Every pin passes through a two-flop synchroniser. Edges are found by comparing the synchronised sample with the sample one cycle older. When both edge selects of a pin are clear, the pin is level-sensed instead.

The host zeroes the configuration, programs the pins it cares about, clears status, and then pulses a sleep-entry doorbell to arm the monitor. The first enabled pending pin after the doorbell produces a one-cycle wake pulse. A summary interrupt stays high for as long as any status bit is set together with its enable bit. Status is never cleared by the hardware, so after waking the host can read it to find the cause.

Top module: `wkmon_top`

## Requirements
- R1: While reset is high, every register word reads zero, `wake_pulse` is 0 and `irq_out` is 0.
- R2: Word addresses 0 and 1 are two 32-bit read/write timer storage words. The five banks follow in the order enable (0), falling (1), rising (2), polarity (3), status (4). Bank b, word index i sits at word address b*STRIDE + i + 2, with STRIDE = ceil(NUM_PINS/32). Pin p is bit p%32 of word p/32.
- R3: A pin whose rising bit is set records a status event on each 0-to-1 transition of its synchronised input.
- R4: A pin whose falling bit is set records a status event on each 1-to-0 transition.
- R5: With both edge bits set, a pin records both transitions.
- R6: With both edge bits clear, a pin is level-sensed and records an event on every cycle its input equals the polarity bit (1 = active high, 0 = active low).
- R7: Status bits are sticky. They change only when the status word is written. A write stores the written value, except that an event detected in the same cycle still sets its bit.
- R8: `irq_out` is the OR over all pins of status AND enable. A pin with enable clear never causes `irq_out` or `wake_pulse`.
- R9: After a `sleep_req` pulse, the first cycle with any enabled pending bit produces exactly one single-cycle `wake_pulse`. Without a new doorbell no further pulse follows, and no pulse occurs without a doorbell.
- R10: A pin change applied before clock edge k is visible in status after edge k+2 and not after edge k+1.
- R11: Writes to addresses beyond the last bank are ignored and reads there return zero. Status and configuration bits above NUM_PINS-1 read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Always-on clock |
| rst | input | 1 | Synchronous active-high reset |
| pins_in | input | NUM_PINS | Asynchronous wake-up pin inputs |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` (combinational) |
| sleep_req | input | 1 | Sleep-entry doorbell pulse; arms monitoring |
| wake_pulse | output | 1 | One-cycle wake request |
| irq_out | output | 1 | Summary interrupt: any enabled pending bit |

## Verification
The assertions rely on two assumptions. First, `sleep_req` and `wr_en` are clean one-cycle-or-longer levels sampled on the clock edge. Second, the pins may toggle at any time, because the assertions only observe the synchronised side. The sticky-status property takes for granted that only a register write can lower a status bit, so it holds whatever the pin activity. The bench drives every input at the falling clock edge. It holds pins stable for several cycles around configuration writes, so that each random round has one well-defined old and new level per pin against which expected status is computed.

// File: rtl/wkmon_pkg.sv
package wkmon_pkg;

    localparam int WORD_W      = 32;
    localparam int NUM_BANKS   = 5;
    localparam int TIMER_WORDS = 2;

    typedef enum int {
        BANK_EN   = 0,
        BANK_FALL = 1,
        BANK_RISE = 2,
        BANK_POL  = 3,
        BANK_STAT = 4
    } bank_e;

    typedef struct packed {
        logic en;
        logic fall;
        logic rise;
        logic pol;
    } pin_cfg_t;

    function automatic int words_for(input int pins);
        return (pins + WORD_W - 1) / WORD_W;
    endfunction

    // Event for one pin from its configuration and synchronised samples.
    function automatic logic pin_event(input pin_cfg_t cfg, input logic cur,
                                       input logic prev);
        logic up, down;
        up   = cur & ~prev;
        down = ~cur & prev;
        if (cfg.rise | cfg.fall)
            return (up & cfg.rise) | (down & cfg.fall);
        else
            return cur ~^ cfg.pol;
    endfunction

endpackage

// File: rtl/wkmon_sync.sv
module wkmon_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] cur,
    output logic [W-1:0] prev
);
    logic [W-1:0] meta_q, cur_q, prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            cur_q  <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= d;
            cur_q  <= meta_q;
            prev_q <= cur_q;
        end
    end

    assign cur  = cur_q;
    assign prev = prev_q;
endmodule

// File: rtl/wkmon_detect.sv
module wkmon_detect
    import wkmon_pkg::*;
#(
    parameter int NUM_PINS = 8
) (
    input  pin_cfg_t [NUM_PINS-1:0] cfg,
    input  logic     [NUM_PINS-1:0] cur,
    input  logic     [NUM_PINS-1:0] prev,
    output logic     [NUM_PINS-1:0] evt
);
    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        assign evt[p] = pin_event(cfg[p], cur[p], prev[p]);
    end
endmodule

// File: rtl/wkmon_regs.sv
module wkmon_regs
    import wkmon_pkg::*;
#(
    parameter int NUM_PINS = 40,
    parameter int ADDR_W   = 6
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [WORD_W-1:0]       wdata,
    output logic [WORD_W-1:0]       rdata,
    input  logic [NUM_PINS-1:0]     evt,
    output pin_cfg_t [NUM_PINS-1:0] cfg,
    output logic [NUM_PINS-1:0]     stat
);
    localparam int STRIDE = words_for(NUM_PINS);
    localparam int PAD_W  = STRIDE * WORD_W;

    function automatic logic [PAD_W-1:0] valid_mask();
        logic [PAD_W-1:0] m;
        for (int i = 0; i < PAD_W; i++) m[i] = (i < NUM_PINS);
        return m;
    endfunction

    localparam logic [PAD_W-1:0] VALID = valid_mask();

    logic [PAD_W-1:0]  bank_q  [NUM_BANKS];
    logic [PAD_W-1:0]  bank_nx [NUM_BANKS];
    logic [WORD_W-1:0] timer_q [TIMER_WORDS];
    logic [PAD_W-1:0]  evt_pad;

    int unsigned a;
    int unsigned idx;
    int          bank_sel;
    logic        hit, is_timer, tsel;

    // Address decode
    always_comb begin
        a        = 32'(addr);
        hit      = 1'b0;
        is_timer = 1'b0;
        tsel     = 1'b0;
        bank_sel = 0;
        idx      = 0;
        if (a < TIMER_WORDS) begin
            is_timer = 1'b1;
            tsel     = a[0];
        end else begin
            for (int b = 0; b < NUM_BANKS; b++) begin
                if (a >= 32'(TIMER_WORDS + b * STRIDE) &&
                    a <  32'(TIMER_WORDS + (b + 1) * STRIDE)) begin
                    hit      = 1'b1;
                    bank_sel = b;
                    idx      = a - 32'(TIMER_WORDS + b * STRIDE);
                end
            end
        end
    end

    always_comb begin
        evt_pad = '0;
        evt_pad[NUM_PINS-1:0] = evt;
    end

    // Next state: write, then sticky event merge, then clip unused bits
    always_comb begin
        for (int b = 0; b < NUM_BANKS; b++) bank_nx[b] = bank_q[b];
        if (wr_en && hit)
            bank_nx[bank_sel][idx*WORD_W +: WORD_W] = wdata;
        bank_nx[BANK_STAT] = bank_nx[BANK_STAT] | evt_pad;
        for (int b = 0; b < NUM_BANKS; b++) bank_nx[b] = bank_nx[b] & VALID;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int b = 0; b < NUM_BANKS; b++) bank_q[b] <= '0;
            for (int t = 0; t < TIMER_WORDS; t++) timer_q[t] <= '0;
        end else begin
            for (int b = 0; b < NUM_BANKS; b++) bank_q[b] <= bank_nx[b];
            if (wr_en && is_timer) timer_q[tsel] <= wdata;
        end
    end

    always_comb begin
        if (is_timer)
            rdata = timer_q[tsel];
        else if (hit)
            rdata = bank_q[bank_sel][idx*WORD_W +: WORD_W];
        else
            rdata = '0;
    end

    always_comb begin
        for (int p = 0; p < NUM_PINS; p++) begin
            cfg[p].en   = bank_q[BANK_EN][p];
            cfg[p].fall = bank_q[BANK_FALL][p];
            cfg[p].rise = bank_q[BANK_RISE][p];
            cfg[p].pol  = bank_q[BANK_POL][p];
        end
        stat = bank_q[BANK_STAT][NUM_PINS-1:0];
    end
endmodule

// File: rtl/wkmon_top.sv
module wkmon_top
    import wkmon_pkg::*;
#(
    parameter int NUM_PINS = 40,
    parameter int ADDR_W   = 6
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_PINS-1:0] pins_in,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [31:0]         wdata,
    output logic [31:0]         rdata,
    input  logic                sleep_req,
    output logic                wake_pulse,
    output logic                irq_out
);
    logic [NUM_PINS-1:0]     cur, prev, evt, stat_vec, en_vec;
    pin_cfg_t [NUM_PINS-1:0] cfg;
    logic                    armed_q, wake_q, fire;

    wkmon_sync #(.W(NUM_PINS)) u_sync (
        .clk(clk), .rst(rst), .d(pins_in), .cur(cur), .prev(prev)
    );

    wkmon_detect #(.NUM_PINS(NUM_PINS)) u_detect (
        .cfg(cfg), .cur(cur), .prev(prev), .evt(evt)
    );

    wkmon_regs #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .evt(evt), .cfg(cfg), .stat(stat_vec)
    );

    always_comb begin
        for (int p = 0; p < NUM_PINS; p++) en_vec[p] = cfg[p].en;
    end

    assign irq_out = |(stat_vec & en_vec);
    assign fire    = armed_q & irq_out;

    // Arming: doorbell sets, the wake it causes clears
    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q <= 1'b0;
            wake_q  <= 1'b0;
        end else begin
            armed_q <= fire ? 1'b0 : (armed_q | sleep_req);
            wake_q  <= fire;
        end
    end

    assign wake_pulse = wake_q;
endmodule

// File: rtl/wkmon_checker.sv
module wkmon_checker #(
    parameter int NUM_PINS = 40
) (
    input logic                clk,
    input logic                rst,
    input logic                wr_en,
    input logic                wake_pulse,
    input logic                irq_out,
    input logic [NUM_PINS-1:0] stat_vec,
    input logic [NUM_PINS-1:0] en_vec
);
    a_r9_single_pulse: assert property (@(posedge clk) disable iff (rst)
        wake_pulse |=> !wake_pulse);

    a_r8_wake_needs_pending: assert property (@(posedge clk) disable iff (rst)
        wake_pulse |-> $past(irq_out));

    a_r7_sticky_status: assert property (@(posedge clk) disable iff (rst)
        !$past(wr_en) |-> ((stat_vec & $past(stat_vec)) == $past(stat_vec)));

    a_r8_disabled_quiet: assert property (@(posedge clk) disable iff (rst)
        (en_vec == '0) |-> (!irq_out && !wake_pulse));

    a_r1_reset_quiet: assert property (@(posedge clk)
        $past(rst) |-> (!wake_pulse && stat_vec == '0));
endmodule

bind wkmon_top wkmon_checker #(.NUM_PINS(NUM_PINS)) u_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wake_pulse(wake_pulse),
    .irq_out(irq_out), .stat_vec(stat_vec), .en_vec(en_vec)
);

// File: tb/wkmon_top_bench.sv
`timescale 1ns/1ps
module wkmon_top_bench;
    localparam int NP = 40;
    localparam int AW = 6;
    // Word addresses with STRIDE = 2
    localparam int A_EN = 2, A_FALL = 4, A_RISE = 6, A_POL = 8, A_STAT = 10;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NP-1:0] pins_in = '0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic          sleep_req = 1'b0;
    logic          wake_pulse, irq_out;

    int n_tests = 0, n_fail = 0, wake_cnt = 0;
    bit done = 1'b0;

    wkmon_top #(.NUM_PINS(NP), .ADDR_W(AW)) u_wkmon_top (
        .clk(clk), .rst(rst), .pins_in(pins_in), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .sleep_req(sleep_req),
        .wake_pulse(wake_pulse), .irq_out(irq_out)
    );

    always #5 clk = ~clk;

    always @(negedge clk) if (!rst && wake_pulse) wake_cnt++;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = AW'(a); wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        @(negedge clk);
        addr = AW'(a);
        #1 d = rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic read_stat(output logic [NP-1:0] s);
        logic [31:0] w0, w1;
        rd(A_STAT, w0);
        rd(A_STAT + 1, w1);
        s = {w1[7:0], w0};
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    // Expected status for one pin after an old->new transition
    function automatic logic exp_bit(input logic r, input logic f, input logic pl,
                                     input logic o, input logic n);
        if (r | f) return (r & ~o & n) | (f & o & ~n);
        return (o == pl) | (n == pl);
    endfunction

    initial begin
        #2_000_000;
        n_tests++; n_fail++;
        $display("FAIL R9 watchdog: got timeout expected completion");
        summary();
    end

    initial begin
        logic [31:0]   w;
        logic [NP-1:0] s;
        int            seed;
        seed = $urandom(32'd2024);

        // R1: reset state, read while reset is held
        idle(3);
        for (int a = 0; a < 12; a++) begin
            rd(a, w);
            chk($sformatf("R1 word %0d", a), 64'(w), 64'd0);
        end
        chk("R1 wake", 64'(wake_pulse), 64'd0);
        chk("R1 irq", 64'(irq_out), 64'd0);
        @(negedge clk) rst = 1'b0;

        // R2: timer words and bank placement
        wr(0, 32'hCAFE_0001); wr(1, 32'h1234_5678);
        rd(0, w); chk("R2 timer0", 64'(w), 64'hCAFE_0001);
        rd(1, w); chk("R2 timer1", 64'(w), 64'h1234_5678);
        wr(A_POL + 1, 32'h0000_00A5);
        rd(A_POL + 1, w); chk("R2 polarity word 1", 64'(w), 64'hA5);
        rd(A_POL, w);     chk("R2 polarity word 0 untouched", 64'(w), 64'd0);
        wr(A_POL + 1, 32'h0);

        // R11: out of range and unused upper bits
        wr(12, 32'hFFFF_FFFF);
        rd(12, w); chk("R11 out of range read", 64'(w), 64'd0);
        wr(A_FALL + 1, 32'hFFFF_FFFF);
        rd(A_FALL + 1, w); chk("R11 upper bits clipped", 64'(w), 64'hFF);
        wr(A_FALL + 1, 32'h0);

        // R10 and R7: latency and stickiness on pin 7, rising only
        wr(A_RISE, 32'h80);
        wr(A_STAT, 32'h0);
        @(negedge clk) pins_in[7] = 1'b1;     // before edge k
        @(negedge clk); addr = AW'(A_STAT);   // after edge k
        @(negedge clk); #1 chk("R10 not yet after k+1", 64'(rdata[7]), 64'd0);
        @(negedge clk); #1 chk("R10 set after k+2", 64'(rdata[7]), 64'd1);
        pins_in[7] = 1'b0;
        idle(5);
        rd(A_STAT, w); chk("R7 sticky after release", 64'(w[7]), 64'd1);
        wr(A_STAT, 32'h0);
        rd(A_STAT, w); chk("R7 cleared by write", 64'(w[7]), 64'd0);
        wr(A_RISE, 32'h0);

        // R8 and R9: pin 5 rising enabled, pin 9 rising disabled
        wr(A_RISE, 32'h220);
        wr(A_EN, 32'h20);
        wr(A_STAT, 32'h0);
        wr(A_STAT + 1, 32'h0);
        idle(2);
        chk("R8 irq idle", 64'(irq_out), 64'd0);
        @(negedge clk) pins_in[9] = 1'b1;
        idle(6);
        rd(A_STAT, w); chk("R8 disabled pin status", 64'(w[9]), 64'd1);
        chk("R8 disabled pin no irq", 64'(irq_out), 64'd0);
        chk("R8 disabled pin no wake", 64'(wake_cnt), 64'd0);
        @(negedge clk) pins_in[5] = 1'b1;
        idle(6);
        chk("R8 irq on enabled pending", 64'(irq_out), 64'd1);
        chk("R9 no wake without doorbell", 64'(wake_cnt), 64'd0);
        wr(A_STAT, 32'h0);
        idle(1);
        chk("R8 irq drops after clear", 64'(irq_out), 64'd0);
        @(negedge clk) sleep_req = 1'b1;
        @(negedge clk) sleep_req = 1'b0;
        pins_in[5] = 1'b0;                    // falling, not selected
        idle(6);
        chk("R3 falling ignored by rise-only pin", 64'(wake_cnt), 64'd0);
        pins_in[5] = 1'b1;
        idle(8);
        chk("R9 one wake after doorbell", 64'(wake_cnt), 64'd1);
        chk("R9 irq held", 64'(irq_out), 64'd1);
        wr(A_STAT, 32'h0);
        @(negedge clk) pins_in[5] = 1'b0;
        @(negedge clk) pins_in[5] = 1'b1;
        idle(8);
        chk("R9 no repeat without doorbell", 64'(wake_cnt), 64'd1);
        pins_in = '0;
        wr(A_EN, 32'h0); wr(A_RISE, 32'h0);

        // R3 R4 R5 R6: constrained random rounds
        for (int r = 0; r < 12; r++) begin
            logic [NP-1:0] en_m, fa_m, ri_m, po_m, o, n, exp_s;
            logic [63:0]   t;
            t = {$urandom(), $urandom()}; en_m = t[NP-1:0];
            t = {$urandom(), $urandom()}; fa_m = t[NP-1:0];
            t = {$urandom(), $urandom()}; ri_m = t[NP-1:0];
            t = {$urandom(), $urandom()}; po_m = t[NP-1:0];
            t = {$urandom(), $urandom()}; o = t[NP-1:0];
            t = {$urandom(), $urandom()}; n = t[NP-1:0];
            if (r == 0) begin fa_m = '1; ri_m = '1; n = ~o; end      // both edges
            if (r == 1) begin fa_m = '0; ri_m = '0; end              // all level
            @(negedge clk) pins_in = o;
            wr(A_EN, en_m[31:0]);   wr(A_EN + 1, 32'(en_m[NP-1:32]));
            wr(A_FALL, fa_m[31:0]); wr(A_FALL + 1, 32'(fa_m[NP-1:32]));
            wr(A_RISE, ri_m[31:0]); wr(A_RISE + 1, 32'(ri_m[NP-1:32]));
            wr(A_POL, po_m[31:0]);  wr(A_POL + 1, 32'(po_m[NP-1:32]));
            idle(4);
            wr(A_STAT, 32'h0); wr(A_STAT + 1, 32'h0);
            @(negedge clk) pins_in = n;
            idle(5);
            for (int p = 0; p < NP; p++)
                exp_s[p] = exp_bit(ri_m[p], fa_m[p], po_m[p], o[p], n[p]);
            read_stat(s);
            chk($sformatf("R3 R4 R5 R6 status round %0d", r), 64'(s), 64'(exp_s));
            chk($sformatf("R8 irq round %0d", r), 64'(irq_out), 64'(|(exp_s & en_m)));
        end
        chk("R9 no wake in unarmed rounds", 64'(wake_cnt), 64'd1);

        done = 1'b1;
        summary();
    end
endmodule